// File: doc/BRIEF.md
# Atomic ALU Admission Controller

This block sits in front of a pool of identical, fully pipelined atomic ALUs that serve a shared L2 cache. Each cycle, up to `LANES` request lanes may each present an address and ask whether an atomic read-modify-write may start. The block answers every lane with a grant in the same cycle. A lane that was granted then commits by raising its reserve strobe in that same cycle, and only a commit is recorded.

ALUs are not tied to cache lines. They form a free pool, so admission has two conditions. The first is a start budget of `NUM_ALU` operations per cycle. The second is a hazard check on the cache line: a line may not start if it already has an operation inside the `LAT`-cycle pipeline window. This includes operations committed earlier in the same cycle by lower-numbered lanes.

Two 32-bit counters track committed operations and refused tries.

Top module: `atom_admit`

## Requirements
- R1: The line address of a lane is its `tryAddr` slice with the low log2(`LINE_BYTES`) bits removed. Two addresses in the same line conflict, and addresses in different lines never do. Lane i uses bit i of each lane vector and bits [i*ADDR_W +: ADDR_W] of `tryAddr`.
- R2: At most `NUM_ALU` operations commit in one cycle. Lane i is granted only while fewer than `NUM_ALU` lower-numbered lanes commit in that cycle.
- R3: A lane is refused when a lower-numbered lane commits the same line in the same cycle. A higher-numbered lane never blocks a lower one.
- R4: A lane is refused when its line was committed 1 to `LAT` cycles earlier.
- R5: A commit that is `LAT`+1 or more cycles old no longer blocks its line.
- R6: With `LAT` = 0, only same-cycle commits are checked. A second operation to one line in one cycle is still refused, and the same line is granted again in the next cycle.
- R7: `grant` is combinational from the present inputs and never asserts without `tryValid`. A granted try without `reserve` leaves no record and is not counted as an operation.
- R8: `reserve` on a lane without a grant is ignored. It adds no record and no operation count.
- R9: `opCount` increases by the number of commits in each cycle. `stallCount` increases by the number of refused tries, where a refused try is a lane with `tryValid`=1 and `grant`=0.
- R10: A synchronous active-high `rst` clears every in-flight record and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tryValid | input | LANES | Per-lane request to start an atomic |
| tryAddr | input | LANES*ADDR_W | Per-lane byte address, with lane i in bits [i*ADDR_W +: ADDR_W] |
| reserve | input | LANES | Per-lane commit of a granted try |
| grant | output | LANES | Per-lane combinational admission answer |
| opCount | output | 32 | Committed atomic operations |
| stallCount | output | 32 | Refused tries |

## Verification
The assertions check on every cycle that the commits respect the per-cycle budget and that no two commits in one cycle share a line. They also check that no commit lands on a line that the history window still reports as busy, that the counters move only when the control reports commits or refusals, and that reset clears both counters.

Only the bench scenarios can show some behaviours, because they depend on a sequence of cycles. These are:
- the exact release cycle of a line after `LAT` cycles;
- the lane ordering of refusals;
- that an unreserved grant or an ungranted reserve leaves nothing behind;
- the instantaneous `LAT` = 0 variant.

// File: rtl/atom_admit_pkg.sv
package atom_admit_pkg;

  // Per-cycle event counts that the control hands to the datapath.
  typedef struct packed {
    logic [7:0] commitCnt;
    logic [7:0] stallCnt;
  } strobe_t;

endpackage

// File: rtl/atom_admit_ctrl.sv
module atom_admit_ctrl
  import atom_admit_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int NUM_ALU = 64,
  parameter int LINE_W  = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        tryValid,
  input  logic [LANES-1:0]        reserve,
  input  logic [LANES-1:0]        histHit,
  input  logic [LANES*LINE_W-1:0] lineFlat,
  output logic [LANES-1:0]        grant,
  output logic [LANES-1:0]        commit,
  output strobe_t                 stb
);

  // Lanes are resolved in index order. Each lane sees the commits of the
  // lanes below it, both for the budget and for the line hazard.
  always_comb begin
    int   early;
    logic clash;
    grant  = '0;
    commit = '0;
    for (int i = 0; i < LANES; i++) begin
      early = 0;
      clash = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (commit[j]) begin
          early = early + 1;
          if (lineFlat[j*LINE_W +: LINE_W] == lineFlat[i*LINE_W +: LINE_W])
            clash = 1'b1;
        end
      end
      grant[i]  = tryValid[i] && !histHit[i] && !clash && (early < NUM_ALU);
      commit[i] = grant[i] && reserve[i];
    end
  end

  always_comb begin
    stb = '0;
    for (int i = 0; i < LANES; i++) begin
      if (commit[i]) stb.commitCnt = stb.commitCnt + 8'd1;
      if (tryValid[i] && !grant[i]) stb.stallCnt = stb.stallCnt + 8'd1;
    end
  end

  // R8: a commit appears only on a lane that both tried and reserved.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_req
      p_commit_req_r8: assert property (@(posedge clk) disable iff (rst)
        commit[i] |-> (tryValid[i] && reserve[i]));
    end
  endgenerate

endmodule

// File: rtl/atom_admit_dp.sv
module atom_admit_dp
  import atom_admit_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int NUM_ALU = 64,
  parameter int LAT     = 0,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*ADDR_W-1:0] tryAddr,
  input  logic [LANES-1:0]        commit,
  input  strobe_t                 stb,
  output logic [LANES*LINE_W-1:0] lineFlat,
  output logic [LANES-1:0]        histHit,
  output logic [31:0]             opCount,
  output logic [31:0]             stallCount
);

  // R1: the line address drops the byte offset inside the line.
  logic [LANES*OFF_W-1:0] unusedOffset;
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_line
      assign lineFlat[i*LINE_W +: LINE_W]   = tryAddr[i*ADDR_W+OFF_W +: LINE_W];
      assign unusedOffset[i*OFF_W +: OFF_W] = tryAddr[i*ADDR_W +: OFF_W];
    end
  endgenerate

  // In-flight history: stage s holds the commits of the cycle s+1 back.
  generate
    if (LAT > 0) begin : g_hist
      logic [LANES-1:0]        histV [LAT];
      logic [LANES*LINE_W-1:0] histL [LAT];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < LAT; s++) histV[s] <= '0;
        end else begin
          histV[0] <= commit;
          histL[0] <= lineFlat;
          for (int s = 1; s < LAT; s++) begin
            histV[s] <= histV[s-1];
            histL[s] <= histL[s-1];
          end
        end
      end

      always_comb begin
        histHit = '0;
        for (int i = 0; i < LANES; i++)
          for (int s = 0; s < LAT; s++)
            for (int j = 0; j < LANES; j++)
              if (histV[s][j] &&
                  histL[s][j*LINE_W +: LINE_W] == lineFlat[i*LINE_W +: LINE_W])
                histHit[i] = 1'b1;
      end

      for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R4: no commit to a line still inside the pipeline window.
        p_no_inflight_r4: assert property (@(posedge clk) disable iff (rst)
          commit[i] |-> !histHit[i]);
      end
    end else begin : g_nohist
      assign histHit = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      opCount    <= '0;
      stallCount <= '0;
    end else begin
      opCount    <= opCount + 32'(stb.commitCnt);
      stallCount <= stallCount + 32'(stb.stallCnt);
    end
  end

  // R2: the per-cycle start budget.
  p_budget_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(commit) <= NUM_ALU);

  // R3: commits in one cycle never share a line.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_pi
      for (genvar j = i + 1; j < LANES; j++) begin : g_pj
        p_one_per_line_r3: assert property (@(posedge clk) disable iff (rst)
          !(commit[i] && commit[j] &&
            lineFlat[i*LINE_W +: LINE_W] == lineFlat[j*LINE_W +: LINE_W]));
      end
    end
  endgenerate

  // R9: the counters move only with reported events.
  p_ops_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stb.commitCnt == 8'd0) |=> $stable(opCount));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stb.stallCnt == 8'd0) |=> $stable(stallCount));

  // R10: reset clears both counters.
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (opCount == 32'd0 && stallCount == 32'd0));

endmodule

// File: rtl/atom_admit.sv
module atom_admit
  import atom_admit_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int NUM_ALU    = 64,
  parameter int LAT        = 0,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        tryValid,
  input  logic [LANES*ADDR_W-1:0] tryAddr,
  input  logic [LANES-1:0]        reserve,
  output logic [LANES-1:0]        grant,
  output logic [31:0]             opCount,
  output logic [31:0]             stallCount
);

  logic [LANES*LINE_W-1:0] lineFlat;
  logic [LANES-1:0]        histHit;
  logic [LANES-1:0]        commit;
  strobe_t                 stb;

  atom_admit_dp #(
    .LANES(LANES), .NUM_ALU(NUM_ALU), .LAT(LAT),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) dp_i (
    .clk(clk), .rst(rst), .tryAddr(tryAddr), .commit(commit), .stb(stb),
    .lineFlat(lineFlat), .histHit(histHit),
    .opCount(opCount), .stallCount(stallCount)
  );

  atom_admit_ctrl #(
    .LANES(LANES), .NUM_ALU(NUM_ALU), .LINE_W(LINE_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .tryValid(tryValid), .reserve(reserve),
    .histHit(histHit), .lineFlat(lineFlat),
    .grant(grant), .commit(commit), .stb(stb)
  );

  // R7: grant never appears without a try.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_top
      p_grant_try_r7: assert property (@(posedge clk) disable iff (rst)
        grant[i] |-> tryValid[i]);
    end
  endgenerate

endmodule

// File: tb/atom_admit_tb_top.sv
module atom_admit_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0]  tv, rv, g;
  logic [63:0] ta;
  logic [31:0] ops, stalls;
  logic [3:0]  tv0, rv0, g0;
  logic [63:0] ta0;
  logic [31:0] ops0, stalls0;

  int checks = 0;
  int fails  = 0;

  atom_admit #(.LANES(4), .NUM_ALU(2), .LAT(2), .ADDR_W(16), .LINE_BYTES(64))
    dut_i (.clk(clk), .rst(rst), .tryValid(tv), .tryAddr(ta), .reserve(rv),
           .grant(g), .opCount(ops), .stallCount(stalls));

  atom_admit #(.LANES(4), .NUM_ALU(64), .LAT(0), .ADDR_W(16), .LINE_BYTES(64))
    dutL0_i (.clk(clk), .rst(rst), .tryValid(tv0), .tryAddr(ta0), .reserve(rv0),
             .grant(g0), .opCount(ops0), .stallCount(stalls0));

  typedef struct packed {
    logic [3:0]  v;
    logic [63:0] addr;  // lane3..lane0, 16 bits each
    logic [3:0]  res;
    logic [3:0]  exp;
  } vec_t;

  // Line = addr >> 6. NUM_ALU = 2, LAT = 2.
  localparam vec_t VEC [9] = '{
    // R2: four lanes try and only two fit the budget; lines 1 and 2 commit
    '{4'b1111, 64'h0100_00C0_0080_0040, 4'b1111, 4'b0011},
    // R4: line 1 is one cycle old and refused; line 8 commits
    '{4'b0011, 64'h0000_0000_0200_0044, 4'b0010, 4'b0010},
    // R4: line 1 is two cycles old and still refused (R1: 0x7F is in line 1)
    '{4'b0001, 64'h0000_0000_0000_007F, 4'b0001, 4'b0000},
    // R5: line 1 is three cycles old and free again; line 8 is two old and refused
    '{4'b0011, 64'h0000_0000_0210_0050, 4'b0001, 4'b0001},
    // R7: line 12 is granted but not reserved
    '{4'b0001, 64'h0000_0000_0000_0300, 4'b0000, 4'b0001},
    // R3: lane 0 commits line 12 and lane 1 (same line) is refused
    '{4'b0011, 64'h0000_0000_0301_0300, 4'b0011, 4'b0001},
    // R7: lane 1 is unreserved, so lane 2 is still within budget
    '{4'b0110, 64'h0000_0440_0400_0000, 4'b0100, 4'b0110},
    // R7: line 16 was never committed and is granted
    '{4'b0001, 64'h0000_0000_0000_0400, 4'b0001, 4'b0001},
    // R8: lines 3 and 4 were reserved without grant in vector 0 and are free
    '{4'b0011, 64'h0000_0000_0100_00C0, 4'b0000, 4'b0011}
  };

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tv = '0; ta = '0; rv = '0; tv0 = '0; ta0 = '0; rv0 = '0;
    repeat (3) @(negedge clk);
    check("R10 reset opCount", ops, 0);
    check("R10 reset stallCount", stalls, 0);
    check("R10 reset grant idle", {28'd0, g}, 0);
    rst = 1'b0;

    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      tv = VEC[k].v; ta = VEC[k].addr; rv = VEC[k].res;
      #1;
      check($sformatf("R2/R3/R4/R5/R7/R8 grant vector %0d", k), {28'd0, g}, {28'd0, VEC[k].exp});
    end
    @(negedge clk);
    tv = '0; rv = '0; ta = '0;
    check("R9 opCount after vectors", ops, 7);
    check("R9 stallCount after vectors", stalls, 6);

    // R10: reset wipes a fresh record of line 20
    tv = 4'b0001; ta = 64'h0000_0000_0000_0500; rv = 4'b0001;
    @(negedge clk);
    tv = '0; rv = '0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 opCount cleared", ops, 0);
    check("R10 stallCount cleared", stalls, 0);
    tv = 4'b0001; ta = 64'h0000_0000_0000_0510; rv = 4'b0001;
    #1;
    check("R10 history cleared grant", {28'd0, g}, 1);
    @(negedge clk);
    tv = '0; rv = '0;
    check("R9 opCount after reset commit", ops, 1);

    // R6: zero-latency variant
    tv0 = 4'b0011; ta0 = 64'h0000_0000_0050_0040; rv0 = 4'b0011;
    #1;
    check("R6 same-cycle same-line refused", {28'd0, g0}, 1);
    @(negedge clk);
    tv0 = 4'b0001; ta0 = 64'h0000_0000_0000_0048; rv0 = 4'b0001;
    #1;
    check("R6 next cycle same line granted", {28'd0, g0}, 1);
    @(negedge clk);
    tv0 = '0; rv0 = '0;
    check("R6 opCount", ops0, 2);
    check("R6 stallCount", stalls0, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule